// File: doc/BRIEF.md
# Operate-Class Microinstruction Executor

This block carries out the register-only ("operate") instructions of a 12-bit machine that has one accumulator and a one-bit link that serves as the accumulator's carry. The caller presents an instruction word, the current accumulator, the link and the operator switch word, and raises `exec_valid` for one cycle. One cycle later the block returns the new accumulator and link with a one-cycle `done` strobe. On the same strobe it may also raise a skip request, which tells the caller to advance the program counter by one extra word, and a halt request.

Each bit of an operate instruction enables its own small action. Several bits may be set in one word, and their actions then run in a fixed order within that single instruction. The first group holds the clears, the complements, the increment and the rotate or half-swap actions. The second group holds the conditional skips, followed by a clear, a switch-word OR and the halt. Fetch, memory access and I/O instructions are handled outside this block. Any word that is not an operate instruction passes the accumulator and the link through unchanged.

Top module: `opr_exec`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ac_out`, `link_out`, `done`, `skip` and `halt` are all 0 until the first operation completes.
- R2: An operation is sampled on a rising edge with `exec_valid` high. Its results appear after that edge, with `done` high for exactly one cycle. `skip` and `halt` are high only together with `done`. Without `exec_valid`, `ac_out` and `link_out` hold their values.
- R3: Bits 11:9 hold the opcode, and operate instructions carry opcode 7. Any other opcode returns `ac_out` = `ac_in` and `link_out` = `link_in`, with no skip and no halt.
- R4: First group (bit 8 = 0). Octal 0200 clears AC and 0100 clears the link. After the clears, 0040 complements AC and 0020 complements the link. For example, 7200 gives AC = 0000.
- R5: In the first group, 0001 adds one to the 13-bit value link:AC after the clears and complements, so a carry out of AC toggles the link. Three successive 7001 after 7200 give AC = 0003.
- R6: In the first group, 0010 rotates link:AC right by one and 0004 rotates it left by one, as the last action. Adding 0002 makes the rotate two places: 7006 rotates left by two, and 7106 clears the link and then rotates left by two. If both 0010 and 0004 are set, no rotate and no swap take place.
- R7: In the first group, 0002 with neither rotate bit set exchanges the upper and lower six-bit halves of AC and leaves the link as it is. For example, 7002 turns 0001 into 0100.
- R8: Second group (bit 8 = 1, bit 0 = 0). The tests are 0100 (AC bit 11 set), 0040 (AC zero) and 0020 (link set). With 0010 clear, the block skips if any selected test is true. With 0010 set, it skips only if every selected test is false, and it always skips when no test is selected. The tests look at the incoming AC and link. For example, 7510 skips when AC bit 11 is 0, and 7420 skips when the link is 1.
- R9: In the second group, after the skip decision, 0200 clears AC and then 0004 ORs `switches` into AC. The link is never changed in this group.
- R10: In the second group, 0002 raises `halt` (7402 halts). No other instruction raises `halt`.
- R11: A word with bit 8 and bit 0 both set passes AC and the link through, with no skip and no halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_valid | input | 1 | Execute the presented instruction this cycle |
| instr | input | 12 | Instruction word |
| ac_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| switches | input | 12 | Operator switch word |
| done | output | 1 | One-cycle strobe when a result is present |
| ac_out | output | 12 | New accumulator |
| link_out | output | 1 | New link bit |
| skip | output | 1 | Skip-next-word request, pulsed with done |
| halt | output | 1 | Halt request, pulsed with done |

## Verification
All 512 operate words are applied to a set of accumulator values for each link value. The accumulator set covers all-zero, all-one, sign-only, one, largest positive and two alternating patterns, and the switch word differs from every one of them. All-zero and all-one values show the carry out of the increment and the zero test. Sign-only and largest positive values tell the sign test apart from the zero test. The alternating patterns show any mistake in rotate direction, rotate distance or half-swap, and the differing switch word exposes an OR into the wrong place. Words with other opcodes are swept to confirm the pass-through. The worked sequences (clear then three increments, two-place rotates, half-swap, the sense-inverted skip, the link skip, halt) are checked as named cases, and the values are held stable between operations.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int AC_W   = 12;
  localparam int HALF_W = AC_W / 2;
  localparam int LW     = AC_W + 1;
  localparam int OPC_W  = 3;

  typedef logic [AC_W-1:0] word_t;
  typedef logic [LW-1:0]   lword_t;

  localparam logic [OPC_W-1:0] OPC_OPERATE = 3'b111;

  // group select and shared positions
  localparam int B_GROUP = 8;
  localparam int B_CLR_A = 7;
  // first group
  localparam int B_CLR_L = 6;
  localparam int B_CPL_A = 5;
  localparam int B_CPL_L = 4;
  localparam int B_ROR   = 3;
  localparam int B_ROL   = 2;
  localparam int B_TWICE = 1;
  localparam int B_INC   = 0;
  // second group
  localparam int B_T_NEG = 6;
  localparam int B_T_ZER = 5;
  localparam int B_T_LNK = 4;
  localparam int B_INVRT = 3;
  localparam int B_OR_SW = 2;
  localparam int B_STOP  = 1;

  function automatic lword_t rot_left1(lword_t v);
    return {v[LW-2:0], v[LW-1]};
  endfunction

  function automatic lword_t rot_right1(lword_t v);
    return {v[0], v[LW-1:1]};
  endfunction

  function automatic word_t swap_halves(word_t a);
    return {a[HALF_W-1:0], a[AC_W-1:HALF_W]};
  endfunction

  function automatic lword_t bump(lword_t v);
    return v + lword_t'(1);
  endfunction
endpackage

// File: rtl/opr_grp1.sv
module opr_grp1
  import opr_pkg::*;
(
  input  word_t ir,
  input  word_t ac,
  input  logic  lk,
  output word_t ac_o,
  output logic  lk_o,
  output logic  rot_used
);
  word_t  a;
  logic   l;
  lword_t v;

  always_comb begin
    a = ir[B_CLR_A] ? '0 : ac;
    l = ir[B_CLR_L] ? 1'b0 : lk;
    if (ir[B_CPL_A]) a = ~a;
    if (ir[B_CPL_L]) l = ~l;
    v = {l, a};
    if (ir[B_INC]) v = bump(v);
    rot_used = 1'b0;
    case ({ir[B_ROR], ir[B_ROL]})
      2'b10: begin
        rot_used = 1'b1;
        v = rot_right1(v);
        if (ir[B_TWICE]) v = rot_right1(v);
      end
      2'b01: begin
        rot_used = 1'b1;
        v = rot_left1(v);
        if (ir[B_TWICE]) v = rot_left1(v);
      end
      2'b00: begin
        if (ir[B_TWICE]) v[AC_W-1:0] = swap_halves(v[AC_W-1:0]);
      end
      default: ;
    endcase
    ac_o = v[AC_W-1:0];
    lk_o = v[LW-1];
  end
endmodule

// File: rtl/opr_grp2.sv
module opr_grp2
  import opr_pkg::*;
(
  input  word_t ir,
  input  word_t ac,
  input  logic  lk,
  input  word_t sw,
  output word_t ac_o,
  output logic  skip_o,
  output logic  halt_o,
  output logic  cond_hit
);
  always_comb begin
    cond_hit = (ir[B_T_NEG] & ac[AC_W-1])
             | (ir[B_T_ZER] & (ac == '0))
             | (ir[B_T_LNK] & lk);
    skip_o = cond_hit ^ ir[B_INVRT];
    ac_o = ir[B_CLR_A] ? '0 : ac;
    if (ir[B_OR_SW]) ac_o = ac_o | sw;
    halt_o = ir[B_STOP];
  end
endmodule

// File: rtl/opr_exec.sv
module opr_exec
  import opr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_valid,
  input  logic [AC_W-1:0]   instr,
  input  logic [AC_W-1:0]   ac_in,
  input  logic              link_in,
  input  logic [AC_W-1:0]   switches,
  output logic              done,
  output logic [AC_W-1:0]   ac_out,
  output logic              link_out,
  output logic              skip,
  output logic              halt
);
  logic  is_opr, is_grp1, is_grp2;
  word_t g1_ac, g2_ac;
  logic  g1_lk, g2_skip, g2_halt, g1_rot, g2_hit;
  word_t nxt_ac;
  logic  nxt_lk, nxt_skip, nxt_halt;

  assign is_opr  = (instr[AC_W-1 -: OPC_W] == OPC_OPERATE);
  assign is_grp1 = is_opr & ~instr[B_GROUP];
  assign is_grp2 = is_opr &  instr[B_GROUP] & ~instr[B_INC];

  opr_grp1 u_g1 (
    .ir(instr), .ac(ac_in), .lk(link_in),
    .ac_o(g1_ac), .lk_o(g1_lk), .rot_used(g1_rot)
  );

  opr_grp2 u_g2 (
    .ir(instr), .ac(ac_in), .lk(link_in), .sw(switches),
    .ac_o(g2_ac), .skip_o(g2_skip), .halt_o(g2_halt), .cond_hit(g2_hit)
  );

  always_comb begin
    nxt_ac   = ac_in;
    nxt_lk   = link_in;
    nxt_skip = 1'b0;
    nxt_halt = 1'b0;
    if (is_grp1) begin
      nxt_ac = g1_ac;
      nxt_lk = g1_lk;
    end else if (is_grp2) begin
      nxt_ac   = g2_ac;
      nxt_skip = g2_skip;
      nxt_halt = g2_halt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      ac_out   <= '0;
      link_out <= 1'b0;
      skip     <= 1'b0;
      halt     <= 1'b0;
    end else begin
      done <= exec_valid;
      skip <= exec_valid & nxt_skip;
      halt <= exec_valid & nxt_halt;
      if (exec_valid) begin
        ac_out   <= nxt_ac;
        link_out <= nxt_lk;
      end
    end
  end
endmodule

// File: rtl/opr_exec_chk.sv
module opr_exec_chk
  import opr_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            exec_valid,
  input logic [AC_W-1:0] instr,
  input logic [AC_W-1:0] ac_in,
  input logic            link_in,
  input logic            done,
  input logic [AC_W-1:0] ac_out,
  input logic            link_out,
  input logic            skip,
  input logic            halt,
  input logic            is_grp2
);
  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |=> done);
  // R2
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_valid |=> !done);
  // R2
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_valid |=> ($stable(ac_out) && $stable(link_out)));
  // R2
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip || halt) |-> done);
  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && instr[AC_W-1 -: OPC_W] != OPC_OPERATE) |=>
      (ac_out == $past(ac_in) && link_out == $past(link_in) && !skip && !halt));
  // R9
  grp2_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && is_grp2) |=> (link_out == $past(link_in)));
  // R10
  halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> $past(exec_valid && is_grp2 && instr[B_STOP]));
  // R11
  grp3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && instr[AC_W-1 -: OPC_W] == OPC_OPERATE && instr[B_GROUP] && instr[B_INC])
      |=> (ac_out == $past(ac_in) && !skip && !halt));
  // R4
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && instr == 12'o7200) |=> (ac_out == '0));
endmodule

bind opr_exec opr_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .instr(instr),
  .ac_in(ac_in), .link_in(link_in), .done(done), .ac_out(ac_out),
  .link_out(link_out), .skip(skip), .halt(halt), .is_grp2(is_grp2)
);

// File: tb/sim_opr_exec.sv
module sim_opr_exec;
  localparam int CLK_P = 10;
  localparam int LIMIT = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_valid = 1'b0;
  logic [11:0] instr = '0, ac_in = '0, switches = '0;
  logic        link_in = 1'b0;
  logic        done, link_out, skip, halt;
  logic [11:0] ac_out;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  opr_exec u0 (
    .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .instr(instr),
    .ac_in(ac_in), .link_in(link_in), .switches(switches), .done(done),
    .ac_out(ac_out), .link_out(link_out), .skip(skip), .halt(halt)
  );

  // arithmetic model on integers
  task automatic model(input logic [11:0] ir, input logic [11:0] a_i, input logic l_i,
                       input logic [11:0] sw, output logic [11:0] ea, output logic el,
                       output logic es, output logic eh);
    int a, l, v, t;
    bit hit;
    a = int'(a_i); l = int'(l_i);
    es = 0; eh = 0;
    if (ir[11:9] != 3'd7 || (ir[8] && ir[0])) begin
      ea = a_i; el = l_i; return;
    end
    if (!ir[8]) begin
      if (ir[7]) a = 0;
      if (ir[6]) l = 0;
      if (ir[5]) a = 4095 - a;
      if (ir[4]) l = 1 - l;
      v = l * 4096 + a;
      if (ir[0]) v = (v + 1) % 8192;
      t = ir[1] ? 2 : 1;
      if (ir[3] && !ir[2]) begin
        for (int k = 0; k < t; k++) v = v / 2 + (v % 2) * 4096;
      end else if (ir[2] && !ir[3]) begin
        for (int k = 0; k < t; k++) v = (v * 2) % 8192 + v / 4096;
      end else if (!ir[2] && !ir[3] && ir[1]) begin
        v = (v / 4096) * 4096 + (v % 64) * 64 + (v % 4096) / 64;
      end
      ea = 12'(v % 4096); el = (v / 4096) != 0;
    end else begin
      hit = (ir[6] && a >= 2048) || (ir[5] && a == 0) || (ir[4] && l == 1);
      es = ir[3] ? !hit : hit;
      ea = ir[7] ? 12'd0 : a_i;
      if (ir[2]) ea = ea | sw;
      el = l_i;
      eh = ir[1];
    end
  endtask

  task automatic check(input string tag, input logic [11:0] ea, input logic el,
                       input logic es, input logic eh, input logic ed);
    total++;
    if (ac_out !== ea || link_out !== el || skip !== es || halt !== eh || done !== ed) begin
      bad++;
      $display("FAIL %s: got ac=%o l=%b skip=%b halt=%b done=%b, want ac=%o l=%b skip=%b halt=%b done=%b",
               tag, ac_out, link_out, skip, halt, done, ea, el, es, eh, ed);
    end
  endtask

  // drive on falling edge, result registered at next rising edge, sample at following falling edge
  task automatic issue(input logic [11:0] ir, input logic [11:0] a, input logic l,
                       input logic [11:0] sw);
    @(negedge clk);
    instr = ir; ac_in = a; link_in = l; switches = sw; exec_valid = 1'b1;
    @(negedge clk);
    exec_valid = 1'b0;
  endtask

  function automatic string tag_of(logic [11:0] ir);
    if (ir[11:9] != 3'd7) return "R3";
    if (ir[8] && ir[0]) return "R11";
    if (ir[8]) begin
      if (ir[1]) return "R10";
      if (ir[7] || ir[2]) return "R9";
      return "R8";
    end
    if (ir[0]) return "R5";
    if (ir[3] || ir[2]) return "R6";
    if (ir[1]) return "R7";
    return "R4";
  endfunction

  initial begin : watchdog
    repeat (LIMIT) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, got timeout want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [11:0] pats [8];
    logic [11:0] ea, keep_a;
    logic el, es, eh, keep_l;
    pats[0] = 12'o0000; pats[1] = 12'o7777; pats[2] = 12'o4000; pats[3] = 12'o0001;
    pats[4] = 12'o3777; pats[5] = 12'o5252; pats[6] = 12'o2525; pats[7] = 12'o0100;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", 12'o0000, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 12'o0000, 1'b0, 1'b0, 1'b0, 1'b0);

    // R5 clear then three increments chained through the outputs
    issue(12'o7200, 12'o5555, 1'b0, 12'o0);
    check("R4", 12'o0000, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 1; k <= 3; k++) begin
      issue(12'o7001, ac_out, link_out, 12'o0);
      check("R5", 12'(k), 1'b0, 1'b0, 1'b0, 1'b1);
    end
    // R5 carry into link
    issue(12'o7001, 12'o7777, 1'b0, 12'o0);
    check("R5", 12'o0000, 1'b1, 1'b0, 1'b0, 1'b1);
    // R6 two-place rotates
    issue(12'o7006, 12'o6000, 1'b0, 12'o0);
    check("R6", 12'o0001, 1'b1, 1'b0, 1'b0, 1'b1);
    issue(12'o7106, 12'o0001, 1'b1, 12'o0);
    check("R6", 12'o0004, 1'b0, 1'b0, 1'b0, 1'b1);
    // R7 half swap
    issue(12'o7002, 12'o0001, 1'b1, 12'o0);
    check("R7", 12'o0100, 1'b1, 1'b0, 1'b0, 1'b1);
    // R8 sign-clear skip and link skip
    issue(12'o7510, 12'o3777, 1'b0, 12'o0);
    check("R8", 12'o3777, 1'b0, 1'b1, 1'b0, 1'b1);
    issue(12'o7510, 12'o4000, 1'b0, 12'o0);
    check("R8", 12'o4000, 1'b0, 1'b0, 1'b0, 1'b1);
    issue(12'o7420, 12'o0000, 1'b1, 12'o0);
    check("R8", 12'o0000, 1'b1, 1'b1, 1'b0, 1'b1);
    // R10 halt
    issue(12'o7402, 12'o1234, 1'b0, 12'o0);
    check("R10", 12'o1234, 1'b0, 1'b0, 1'b1, 1'b1);
    // R2 hold: no strobe, values stable
    keep_a = ac_out; keep_l = link_out;
    repeat (3) begin
      @(negedge clk);
      check("R2", keep_a, keep_l, 1'b0, 1'b0, 1'b0);
    end

    // sweep of all operate words
    for (int op = 0; op < 512; op++) begin
      for (int p = 0; p < 8; p++) begin
        for (int l = 0; l < 2; l++) begin
          logic [11:0] ir, sw;
          ir = 12'o7000 | 12'(op);
          sw = pats[p] ^ 12'o1463;
          issue(ir, pats[p], l[0], sw);
          model(ir, pats[p], l[0], sw, ea, el, es, eh);
          check(tag_of(ir), ea, el, es, eh, 1'b1);
        end
      end
    end
    // R3 other opcodes pass through
    for (int opc = 0; opc < 7; opc++) begin
      for (int p = 0; p < 8; p++) begin
        logic [11:0] ir;
        ir = {3'(opc), 9'o777 ^ 9'(p * 37)};
        issue(ir, pats[p], p[0], 12'o7777);
        check("R3", pats[p], p[0], 1'b0, 1'b0, 1'b1);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule